// File: doc/BRIEF.md
# Multislope Rundown Sequencer

This block sequences the rundown phase of a multislope integrating converter. It runs without pause from reset. Each rundown has the same fixed order of phases:

- a processor window, with the fractional counter off;
- a weight-4 pre-slope that drives the integrator toward a guaranteed zero crossing;
- a run of signed reference slopes of decreasing weight, each stopped at a maximum count or at the count boundary that follows the integrator's zero crossing;
- zero-weight pauses between the later slopes.

Time is measured in ALE clocks, which are the cycles of `clk`. One converter count equals `ALE_PER_CNT` ALE clocks. The zero-crossing input is asynchronous and passes through a two-flop synchronizer. Only its rising edge counts as a crossing, and the slope acts on it at the next count boundary.

The block drives the 3-bit slope code to the reference switches and the enable to the fractional counter. At the end of every processor window that follows a finished rundown, it pulses `done` for one cycle. At the same time it publishes the number of counts each slope ran, together with the two polarity decisions it made. The analog integrator, the comparator and the arithmetic that combines the counts are outside this block.

Top module: `rundown_seq`

## Requirements
- R1: While `rst_n` is low, `slope_code` is 000, `frac_en` is 0 and `done` is 0. After release, the block begins with a processor window of `WIN_CLKS` (33) clocks.
- R2: The pre-slope follows each processor window and lasts exactly `PRE_CNT` (10) counts (50 clocks) with `frac_en` low. Its code is -4 if `integ_pos` was high in the last window cycle and +4 otherwise. That choice is reported on `res_pre_neg`.
- R3: The -4 slope always follows the pre-slope. If `integ_pos` was high in the last pre-slope cycle, the slope aborts after exactly 2 counts, whatever `zc_in` does. `res_abort` is then 1 and `res_m4` is 2.
- R4: Without an abort, the -4 slope runs up to 12 counts and goes straight on to the -3 slope.
- R5: After an aborted -4 slope, one S+0 pause runs, then a +4 slope of up to 12 counts. `res_p4` is 0 whenever no abort occurred.
- R6: The -3, +2 and -1 slopes follow in that order, with maximum lengths of 16, 17 and 18 counts. Every counted slope (-4 unaborted, +4, -3, +2, -1) ends early on a crossing. A rising edge of `zc_in` held at least three clocks from the first clock of count j (counting from 0 at slope start) ends the slope after j+1 counts, when that is below the maximum.
- R7: Each S+0 pause lasts exactly `PAUSE_CLKS` (2) clocks, with code 000 and `frac_en` high. One pause follows each of the -3, +2 and -1 slopes.
- R8: The slope code places polarity in bit 2, where 1 means negative. The codes are: S+0 = 000, +4 = 001, +2 = 010, -4 = 101, -3 = 110, -1 = 111. No other code is produced.
- R9: `frac_en` is high from the end of the pre-slope to the end of the pause after the -1 slope. It is low in the processor window and the pre-slope. The window shows code 000.
- R10: `done` is high for one cycle, the first cycle of a pre-slope, except for the first pre-slope after reset. At that point `res_m4`, `res_p4`, `res_m3`, `res_p2`, `res_m1`, `res_abort` and `res_pre_neg` take the values of the rundown just finished. They hold them until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ALE clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_in | input | 1 | Zero-crossing indication, asynchronous, rising edge = crossing |
| integ_pos | input | 1 | Integrator output positive, sampled at the end of window and pre-slope |
| slope_code | output | 3 | Active reference slope, bit 2 = negative polarity |
| frac_en | output | 1 | Fractional counter enable |
| done | output | 1 | One-cycle pulse: result ports updated |
| res_m4 | output | CNT_W | Counts run by the -4 slope |
| res_p4 | output | CNT_W | Counts run by the +4 slope (0 if not taken) |
| res_m3 | output | CNT_W | Counts run by the -3 slope |
| res_p2 | output | CNT_W | Counts run by the +2 slope |
| res_m1 | output | CNT_W | Counts run by the -1 slope |
| res_abort | output | 1 | The -4 slope aborted and the +4 branch ran |
| res_pre_neg | output | 1 | The pre-slope used -4 |

## Verification
The hardest paths to reach are the aborted -4 branch with a crossing pulse arriving inside it, and crossings that land on the last allowed count of a slope. In both, an early stop looks the same as a slope running to its maximum. The stimulus follows the slope code and enable at the ports to find each phase start. It then raises `zc_in` exactly at the first clock of a chosen count, and it sets `integ_pos` at the start of the window and of the pre-slope. Directed rundowns cover crossings at count 0, at the last count, during an abort, and not at all. Seeded random rundowns cover the rest.

// File: rtl/rundown_seq_pkg.sv
package rundown_seq_pkg;

  typedef enum logic [3:0] {
    ST_WIN, ST_PRE, ST_M4, ST_ZA, ST_P4,
    ST_M3, ST_Z3, ST_P2, ST_Z2, ST_M1, ST_Z1
  } rds_state_e;

  // slope codes, bit 2 is the polarity (1 = negative)
  localparam logic [2:0] CODE_ZERO = 3'b000;
  localparam logic [2:0] CODE_P4   = 3'b001;
  localparam logic [2:0] CODE_P2   = 3'b010;
  localparam logic [2:0] CODE_M4   = 3'b101;
  localparam logic [2:0] CODE_M3   = 3'b110;
  localparam logic [2:0] CODE_M1   = 3'b111;

  // result slots
  localparam int NUM_SLOTS = 5;
  localparam logic [2:0] SL_M4 = 3'd0;
  localparam logic [2:0] SL_P4 = 3'd1;
  localparam logic [2:0] SL_M3 = 3'd2;
  localparam logic [2:0] SL_P2 = 3'd3;
  localparam logic [2:0] SL_M1 = 3'd4;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rds_zc_sync.sv
module rds_zc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zc_in,
  input  logic clr,
  output logic zc_flag
);
  // STAGES synchronizer flops plus one history flop for edge detect
  logic [STAGES:0] sh_q;
  logic            rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], zc_in};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  // sticky crossing flag, cleared at each phase change (clear wins)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    zc_flag <= 1'b0;
    else if (clr)  zc_flag <= 1'b0;
    else if (rise) zc_flag <= 1'b1;
  end
endmodule

// File: rtl/rds_timer.sv
module rds_timer #(
  parameter int ALE_PER_CNT = 5,
  parameter int CNT_W       = 5,
  parameter int PH_W        = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic             tick,
  output logic [CNT_W-1:0] adc_cnt,
  output logic [PH_W-1:0]  ph_clk
);
  localparam int ALE_W = (ALE_PER_CNT > 1) ? $clog2(ALE_PER_CNT) : 1;
  localparam logic [ALE_W-1:0] ALE_LAST = ALE_W'(ALE_PER_CNT - 1);

  logic [ALE_W-1:0] ale_q;

  assign tick = (ale_q == ALE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q   <= '0;
      adc_cnt <= '0;
      ph_clk  <= '0;
    end else if (restart) begin
      ale_q   <= '0;
      adc_cnt <= '0;
      ph_clk  <= '0;
    end else begin
      ale_q  <= tick ? '0 : ale_q + ALE_W'(1);
      ph_clk <= (&ph_clk) ? ph_clk : ph_clk + PH_W'(1);
      if (tick && !(&adc_cnt)) adc_cnt <= adc_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rds_fsm.sv
module rds_fsm
  import rundown_seq_pkg::*;
#(
  parameter int PRE_CNT    = 10,
  parameter int ABORT_CNT  = 2,
  parameter int M4_MAX     = 12,
  parameter int P4_MAX     = 12,
  parameter int M3_MAX     = 16,
  parameter int P2_MAX     = 17,
  parameter int M1_MAX     = 18,
  parameter int PAUSE_CLKS = 2,
  parameter int WIN_CLKS   = 33,
  parameter int CNT_W      = 5,
  parameter int PH_W       = 7
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                tick,
  input  logic [CNT_W-1:0]                    adc_cnt,
  input  logic [PH_W-1:0]                     ph_clk,
  input  logic                                zc_flag,
  input  logic                                integ_pos,
  output logic                                restart,
  output logic [2:0]                          slope_code,
  output logic                                frac_en,
  output logic                                done,
  output logic [NUM_SLOTS-1:0][CNT_W-1:0]     res_cnt,
  output logic                                res_abort,
  output logic                                res_pre_neg
);
  localparam logic [PH_W-1:0]  WIN_LAST   = PH_W'(WIN_CLKS - 1);
  localparam logic [PH_W-1:0]  PAUSE_LAST = PH_W'(PAUSE_CLKS - 1);
  localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_CNT - 1);
  localparam logic [CNT_W-1:0] ABORT_LAST = CNT_W'(ABORT_CNT - 1);
  localparam logic [CNT_W-1:0] M4_LAST    = CNT_W'(M4_MAX - 1);
  localparam logic [CNT_W-1:0] P4_LAST    = CNT_W'(P4_MAX - 1);
  localparam logic [CNT_W-1:0] M3_LAST    = CNT_W'(M3_MAX - 1);
  localparam logic [CNT_W-1:0] P2_LAST    = CNT_W'(P2_MAX - 1);
  localparam logic [CNT_W-1:0] M1_LAST    = CNT_W'(M1_MAX - 1);

  rds_state_e state_q, state_d;
  logic       phase_end;
  logic       wr_en;
  logic [2:0] wr_slot;
  logic       abort_q, pre_neg_q, have_res_q;
  logic       cross_tick;
  logic       clr_work, publish;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] work_q;

  assign cross_tick = tick & zc_flag;

  always_comb begin
    phase_end = 1'b0;
    state_d   = state_q;
    wr_en     = 1'b0;
    wr_slot   = SL_M4;
    unique case (state_q)
      ST_WIN: begin
        phase_end = (ph_clk == WIN_LAST);
        state_d   = ST_PRE;
      end
      ST_PRE: begin
        phase_end = tick && (adc_cnt == PRE_LAST);
        state_d   = ST_M4;
      end
      ST_M4: begin
        if (abort_q) phase_end = tick && (adc_cnt == ABORT_LAST);
        else         phase_end = cross_tick || (tick && (adc_cnt == M4_LAST));
        state_d = abort_q ? ST_ZA : ST_M3;
        wr_en   = phase_end;
        wr_slot = SL_M4;
      end
      ST_ZA: begin
        phase_end = (ph_clk == PAUSE_LAST);
        state_d   = ST_P4;
      end
      ST_P4: begin
        phase_end = cross_tick || (tick && (adc_cnt == P4_LAST));
        state_d   = ST_M3;
        wr_en     = phase_end;
        wr_slot   = SL_P4;
      end
      ST_M3: begin
        phase_end = cross_tick || (tick && (adc_cnt == M3_LAST));
        state_d   = ST_Z3;
        wr_en     = phase_end;
        wr_slot   = SL_M3;
      end
      ST_Z3: begin
        phase_end = (ph_clk == PAUSE_LAST);
        state_d   = ST_P2;
      end
      ST_P2: begin
        phase_end = cross_tick || (tick && (adc_cnt == P2_LAST));
        state_d   = ST_Z2;
        wr_en     = phase_end;
        wr_slot   = SL_P2;
      end
      ST_Z2: begin
        phase_end = (ph_clk == PAUSE_LAST);
        state_d   = ST_M1;
      end
      ST_M1: begin
        phase_end = cross_tick || (tick && (adc_cnt == M1_LAST));
        state_d   = ST_Z1;
        wr_en     = phase_end;
        wr_slot   = SL_M1;
      end
      ST_Z1: begin
        phase_end = (ph_clk == PAUSE_LAST);
        state_d   = ST_WIN;
      end
      default: begin
        phase_end = 1'b1;
        state_d   = ST_WIN;
      end
    endcase
  end

  assign restart  = phase_end;
  assign clr_work = (state_q == ST_WIN) && phase_end;
  assign publish  = clr_work && have_res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_WIN;
      abort_q    <= 1'b0;
      pre_neg_q  <= 1'b0;
      have_res_q <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= publish;
      if (phase_end) state_q <= state_d;
      if (clr_work) pre_neg_q <= integ_pos;
      if ((state_q == ST_PRE) && phase_end) abort_q <= integ_pos;
      if ((state_q == ST_Z1) && phase_end) have_res_q <= 1'b1;
    end
  end

  // per-slope working counts and published copies
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q      <= '0;
      res_cnt     <= '0;
      res_abort   <= 1'b0;
      res_pre_neg <= 1'b0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (clr_work)
          work_q[s] <= '0;
        else if (wr_en && (wr_slot == 3'(s)))
          work_q[s] <= adc_cnt + CNT_W'(1);
        if (publish) res_cnt[s] <= work_q[s];
      end
      if (publish) begin
        res_abort   <= abort_q;
        res_pre_neg <= pre_neg_q;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PRE:  slope_code = pre_neg_q ? CODE_M4 : CODE_P4;
      ST_M4:   slope_code = CODE_M4;
      ST_P4:   slope_code = CODE_P4;
      ST_M3:   slope_code = CODE_M3;
      ST_P2:   slope_code = CODE_P2;
      ST_M1:   slope_code = CODE_M1;
      default: slope_code = CODE_ZERO;
    endcase
  end

  assign frac_en = (state_q != ST_WIN) && (state_q != ST_PRE);
endmodule

// File: rtl/rundown_seq.sv
module rundown_seq
  import rundown_seq_pkg::*;
#(
  parameter int ALE_PER_CNT = 5,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_CNT     = 10,
  parameter int ABORT_CNT   = 2,
  parameter int M4_MAX      = 12,
  parameter int P4_MAX      = 12,
  parameter int M3_MAX      = 16,
  parameter int P2_MAX      = 17,
  parameter int M1_MAX      = 18,
  parameter int PAUSE_CLKS  = 2,
  parameter int WIN_CLKS    = 33,
  localparam int MAX_CNT    = max_of(max_of(max_of(M4_MAX, P4_MAX), max_of(M3_MAX, P2_MAX)),
                                     max_of(M1_MAX, PRE_CNT)),
  localparam int CNT_W      = $clog2(MAX_CNT + 1),
  localparam int PH_W       = $clog2(max_of(MAX_CNT * ALE_PER_CNT, WIN_CLKS) + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_in,
  input  logic             integ_pos,
  output logic [2:0]       slope_code,
  output logic             frac_en,
  output logic             done,
  output logic [CNT_W-1:0] res_m4,
  output logic [CNT_W-1:0] res_p4,
  output logic [CNT_W-1:0] res_m3,
  output logic [CNT_W-1:0] res_p2,
  output logic [CNT_W-1:0] res_m1,
  output logic             res_abort,
  output logic             res_pre_neg
);
  logic                            restart;
  logic                            tick;
  logic                            zc_flag;
  logic [CNT_W-1:0]                adc_cnt;
  logic [PH_W-1:0]                 ph_clk;
  logic [NUM_SLOTS-1:0][CNT_W-1:0] res_cnt;

  rds_zc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .zc_in   (zc_in),
    .clr     (restart),
    .zc_flag (zc_flag)
  );

  rds_timer #(.ALE_PER_CNT(ALE_PER_CNT), .CNT_W(CNT_W), .PH_W(PH_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (tick),
    .adc_cnt (adc_cnt),
    .ph_clk  (ph_clk)
  );

  rds_fsm #(
    .PRE_CNT(PRE_CNT), .ABORT_CNT(ABORT_CNT), .M4_MAX(M4_MAX), .P4_MAX(P4_MAX),
    .M3_MAX(M3_MAX), .P2_MAX(P2_MAX), .M1_MAX(M1_MAX), .PAUSE_CLKS(PAUSE_CLKS),
    .WIN_CLKS(WIN_CLKS), .CNT_W(CNT_W), .PH_W(PH_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .adc_cnt     (adc_cnt),
    .ph_clk      (ph_clk),
    .zc_flag     (zc_flag),
    .integ_pos   (integ_pos),
    .restart     (restart),
    .slope_code  (slope_code),
    .frac_en     (frac_en),
    .done        (done),
    .res_cnt     (res_cnt),
    .res_abort   (res_abort),
    .res_pre_neg (res_pre_neg)
  );

  assign res_m4 = res_cnt[SL_M4];
  assign res_p4 = res_cnt[SL_P4];
  assign res_m3 = res_cnt[SL_M3];
  assign res_p2 = res_cnt[SL_P2];
  assign res_m1 = res_cnt[SL_M1];
endmodule

// File: rtl/rundown_seq_chk.sv
module rundown_seq_chk #(
  parameter int ALE_PER_CNT = 5,
  parameter int ABORT_CNT   = 2,
  parameter int M1_MAX      = 18,
  parameter int PAUSE_CLKS  = 2,
  parameter int CNT_W       = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       slope_code,
  input logic             frac_en,
  input logic             done,
  input logic [CNT_W-1:0] res_m4,
  input logic [CNT_W-1:0] res_p4,
  input logic [CNT_W-1:0] res_m3,
  input logic [CNT_W-1:0] res_p2,
  input logic [CNT_W-1:0] res_m1,
  input logic             res_abort,
  input logic             res_pre_neg
);
  localparam logic [7:0] SLOPE_LIM = 8'(M1_MAX * ALE_PER_CNT - 1);
  localparam logic [7:0] PAUSE_LIM = 8'(PAUSE_CLKS - 1);

  logic [3:0] key, prev_key;
  logic [7:0] run_q;
  logic       same;

  assign key  = {slope_code, frac_en};
  assign same = (key == prev_key);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_key <= 4'b0000;
      run_q    <= '0;
    end else begin
      prev_key <= key;
      run_q    <= same ? ((&run_q) ? run_q : run_q + 8'd1) : 8'd0;
    end
  end

  p_pause_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slope_code == 3'b000 && frac_en && same) |-> (run_q < PAUSE_LIM));

  p_slope_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slope_code != 3'b000 && frac_en && same) |-> (run_q < SLOPE_LIM));

  p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slope_code != 3'b011) && (slope_code != 3'b100));

  p_dark_codes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frac_en |-> (slope_code == 3'b000 || slope_code == 3'b001 || slope_code == 3'b101));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({res_m4, res_p4, res_m3, res_p2, res_m1, res_abort, res_pre_neg}));

  p_abort_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_abort |-> (res_m4 == CNT_W'(ABORT_CNT)));

  p_no_p4_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !res_abort |-> (res_p4 == '0));

  p_done_in_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!frac_en && slope_code != 3'b000));
endmodule

bind rundown_seq rundown_seq_chk #(
  .ALE_PER_CNT(ALE_PER_CNT), .ABORT_CNT(ABORT_CNT), .M1_MAX(M1_MAX),
  .PAUSE_CLKS(PAUSE_CLKS), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/rundown_seq_tb_top.sv
`timescale 1ns/1ps
module rundown_seq_tb_top;
  localparam int NUM_RD = 26;
  localparam int ALE    = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       zc_in = 1'b0;
  logic       integ_pos = 1'b0;
  logic [2:0] slope_code;
  logic       frac_en, done;
  logic [4:0] res_m4, res_p4, res_m3, res_p2, res_m1;
  logic       res_abort, res_pre_neg;

  always #2 clk = ~clk;

  rundown_seq dut_i (
    .clk(clk), .rst_n(rst_n), .zc_in(zc_in), .integ_pos(integ_pos),
    .slope_code(slope_code), .frac_en(frac_en), .done(done),
    .res_m4(res_m4), .res_p4(res_p4), .res_m3(res_m3), .res_p2(res_p2),
    .res_m1(res_m1), .res_abort(res_abort), .res_pre_neg(res_pre_neg)
  );

  int checks = 0;
  int errors = 0;

  // plan for the current rundown
  bit p_neg, p_abort;
  int j4, jp4, j3, j2, j1;
  int    e_key [12];
  int    e_len [12];
  int    e_j   [12];
  string e_req [12];
  int    e_n;
  // expected results: pending (current plan) and published (previous plan)
  bit pend_valid = 0, ex_valid = 0;
  int pend_m4, pend_p4, pend_m3, pend_p2, pend_m1;
  bit pend_ab, pend_pn;
  int ex_m4, ex_p4, ex_m3, ex_p2, ex_m1;
  bit ex_ab, ex_pn;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int slen(input int mx, input int j);
    if (j >= 0 && j + 1 < mx) return j + 1;
    return mx;
  endfunction

  function automatic int rj(input int mx);
    return int'($urandom_range(mx + 1, 0)) - 1;
  endfunction

  task automatic add(input int key, input int len, input int j, input string req);
    e_key[e_n] = key; e_len[e_n] = len; e_j[e_n] = j; e_req[e_n] = req;
    e_n++;
  endtask

  task automatic make_plan(input int rd);
    ex_valid = pend_valid;
    ex_m4 = pend_m4; ex_p4 = pend_p4; ex_m3 = pend_m3; ex_p2 = pend_p2; ex_m1 = pend_m1;
    ex_ab = pend_ab; ex_pn = pend_pn;
    case (rd)
      0: begin p_neg = 0; p_abort = 0; j4 = -1; jp4 = -1; j3 = -1; j2 = -1; j1 = -1; end
      1: begin p_neg = 1; p_abort = 1; j4 = 0;  jp4 = 0;  j3 = 15; j2 = 0;  j1 = 17; end
      2: begin p_neg = 0; p_abort = 1; j4 = 1;  jp4 = 11; j3 = 0;  j2 = 16; j1 = 0;  end
      3: begin p_neg = 1; p_abort = 0; j4 = 0;  jp4 = -1; j3 = 5;  j2 = 9;  j1 = 3;  end
      4: begin p_neg = 0; p_abort = 0; j4 = 11; jp4 = -1; j3 = 14; j2 = 15; j1 = 16; end
      default: begin
        p_neg = 1'($urandom); p_abort = 1'($urandom);
        j4 = rj(12); jp4 = rj(12); j3 = rj(16); j2 = rj(17); j1 = rj(18);
      end
    endcase
    e_n = 0;
    add(0, 33, -1, "R9 window");                                   // R1 first window too
    add((p_neg ? 5 : 1) * 2, 10 * ALE, -1, "R2 pre-slope");
    add(5 * 2 + 1, (p_abort ? 2 : slen(12, j4)) * ALE, j4, p_abort ? "R3 aborted -4" : "R4 -4 slope");
    if (p_abort) begin
      add(1, 2, -1, "R5 pause after abort");
      add(1 * 2 + 1, slen(12, jp4) * ALE, jp4, "R5 +4 slope");
    end
    add(6 * 2 + 1, slen(16, j3) * ALE, j3, "R6 -3 slope");
    add(1, 2, -1, "R7 pause after -3");
    add(2 * 2 + 1, slen(17, j2) * ALE, j2, "R6 +2 slope");
    add(1, 2, -1, "R7 pause after +2");
    add(7 * 2 + 1, slen(18, j1) * ALE, j1, "R6 -1 slope");
    add(1, 2, -1, "R7 pause after -1");
    pend_valid = 1;
    pend_m4 = p_abort ? 2 : slen(12, j4);
    pend_p4 = p_abort ? slen(12, jp4) : 0;
    pend_m3 = slen(16, j3); pend_p2 = slen(17, j2); pend_m1 = slen(18, j1);
    pend_ab = p_abort; pend_pn = p_neg;
  endtask

  initial begin
    int prev, key, run, ph, idx, rd, zhold, cyc;
    bit wd;
    void'($urandom(32'd4242));
    rd = 0; make_plan(rd); integ_pos = p_neg;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(slope_code == 3'b000, "R1", "slope_code in reset", int'(slope_code), 0);
    chk(frac_en == 1'b0, "R1", "frac_en in reset", int'(frac_en), 0);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    prev = 0; run = 0; ph = 0; idx = 0; zhold = 0; cyc = 0; wd = 0;
    while (rd < NUM_RD) begin
      key = int'(slope_code) * 2 + int'(frac_en);
      if (key != prev) begin
        if (idx < e_n) begin
          chk(prev == e_key[idx], e_req[idx], "phase code/enable", prev, e_key[idx]);
          chk(run == e_len[idx], e_req[idx], "phase length in clocks", run, e_len[idx]);
        end else begin
          chk(1'b0, "R6", "phase beyond sequence", idx, e_n);
        end
        idx++;
        if (key == 0) begin
          rd++;
          if (rd < NUM_RD) make_plan(rd);
          idx = 0;
          integ_pos = p_neg;
        end else if (idx == 1) begin
          chk(done == ex_valid, "R10", "done at pre-slope start", int'(done), int'(ex_valid));
          if (ex_valid) begin
            chk(int'(res_m4) == ex_m4, "R3", "res_m4", int'(res_m4), ex_m4);
            chk(int'(res_p4) == ex_p4, "R5", "res_p4", int'(res_p4), ex_p4);
            chk(int'(res_m3) == ex_m3, "R6", "res_m3", int'(res_m3), ex_m3);
            chk(int'(res_p2) == ex_p2, "R6", "res_p2", int'(res_p2), ex_p2);
            chk(int'(res_m1) == ex_m1, "R6", "res_m1", int'(res_m1), ex_m1);
            chk(res_abort == ex_ab, "R3", "res_abort", int'(res_abort), int'(ex_ab));
            chk(res_pre_neg == ex_pn, "R2", "res_pre_neg", int'(res_pre_neg), int'(ex_pn));
          end
          integ_pos = p_abort;
        end
        prev = key; run = 0; ph = 0;
      end
      if (idx < e_n && e_j[idx] >= 0 && ph == ALE * e_j[idx]) begin
        zc_in = 1'b1; zhold = 3;
      end else if (zhold > 0) begin
        zhold--;
        if (zhold == 0) zc_in = 1'b0;
      end
      run++; ph++; cyc++;
      if (run > 400 || cyc > 150000) begin
        wd = 1;
        break;
      end
      @(negedge clk);
    end
    if (wd) chk(1'b0, "R6", "watchdog expired, cycles", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule